// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block times the serial clock of an I2C master from the peripheral clock. It sets the length of each SCL low phase and each SCL high phase, and the point inside the low phase where SDA may change. It reports each of these points to the byte engine as a one-cycle strobe: the SCL falling edge, the SDA change point, the SCL rising edge and the mid-high sample point. The engine uses the strobes to drive the bus pins and to sample data.

The timing comes from one 32-bit configuration word. The word holds a low divider, a high divider, a shared power-of-two prescale exponent and a hold count. Each phase lasts the divider shifted left by the exponent, plus three cycles of fixed overhead. A new word is taken only when a low phase begins, so a phase in progress is never cut short or stretched by a reprogram. A stall input comes from the pin logic. It holds the high phase in place while a slave keeps SCL low.

Top module: `scl_wave_gen`

## Requirements
- R1: While reset is asserted, and afterwards until run_i is sampled high, scl_o is 1 and all four strobes are 0.
- R2: The low phase lasts (L << E) + 3 cycles, measured from fall_stb_o to the following rise_stb_o. L is cfg_i[7:0] and E is the exponent in cfg_i[18:16].
- R3: The high phase lasts (H << E) + 3 cycles, measured from rise_stb_o to the next fall_stb_o. H is cfg_i[15:8], and it is set apart from L.
- R4: sda_stb_o pulses (D + 3) cycles after fall_stb_o, where D is the hold count in cfg_i[28:24].
- R5: When D + 3 is not less than the low phase length, sda_stb_o pulses in the last cycle of the low phase instead.
- R6: mid_stb_o pulses floor(high length / 2) cycles after rise_stb_o.
- R7: cfg_i is captured only at the clock edge that begins a low phase. A change made at any other time first shows in the next period.
- R8: While stall_i is 1 in the high phase, the phase counter holds and no high-phase strobe is given. rise_stb_o, mid_stb_o and the next fall are all delayed by the number of stalled cycles.
- R9: stall_i has no effect during the low phase.
- R10: fall_stb_o pulses in the cycle after run_i is sampled high in idle. When run_i is low at the end of a high phase, the generator goes idle with scl_o at 1.
- R11: No two strobes are active in the same cycle, and scl_o is 0 exactly from the fall_stb_o cycle up to the rise_stb_o cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Keep generating SCL periods |
| stall_i | input | 1 | SCL released but seen low; holds the high phase |
| cfg_i | input | 32 | Waveform configuration word |
| scl_o | output | 1 | SCL level to drive (1 = released) |
| fall_stb_o | output | 1 | First cycle of the low phase |
| sda_stb_o | output | 1 | SDA may change in this cycle |
| rise_stb_o | output | 1 | First unstalled cycle of the high phase |
| mid_stb_o | output | 1 | Mid-high sample point |

## Verification
The hardest cases to reach from the ports are a configuration that changes while a period is in flight and a stall that lands exactly on the first high cycle. The driver computes every strobe time for a whole sequence ahead of time and queues the times. It then writes a new configuration word one cycle after the fall strobe and raises the stall in the cycle where the rise would have come. It also pulses the stall inside a low phase. Any strobe that moves by even one cycle fails the cycle-stamp comparison.

// File: rtl/scl_wave_pkg.sv
package scl_wave_pkg;

    parameter int DIV_W   = 8;
    parameter int EXP_W   = 3;
    parameter int HOLD_W  = 5;
    parameter int CFG_W   = 32;
    parameter int OVERHEAD = 3;

    // bit positions inside the configuration word
    parameter int LO_LSB   = 0;
    parameter int HI_LSB   = 8;
    parameter int EXP_LSB  = 16;
    parameter int HOLD_LSB = 24;

    localparam int CNT_W = DIV_W + (2 ** EXP_W) - 1 + 1;

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [EXP_W-1:0]  expo;
        logic [DIV_W-1:0]  hi_div;
        logic [DIV_W-1:0]  lo_div;
    } wave_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    function automatic wave_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        wave_cfg_t c;
        c.lo_div = w[LO_LSB +: DIV_W];
        c.hi_div = w[HI_LSB +: DIV_W];
        c.expo   = w[EXP_LSB +: EXP_W];
        c.hold   = w[HOLD_LSB +: HOLD_W];
        return c;
    endfunction

endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
    parameter int DIV_W    = 8,
    parameter int EXP_W    = 3,
    parameter int CNT_W    = 16,
    parameter int OVERHEAD = 3
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic [CNT_W-1:0] len_o
);
    localparam int PAD_W = CNT_W - DIV_W;

    logic [CNT_W-1:0] scaled;

    always_comb begin
        scaled = {{PAD_W{1'b0}}, div_i} << exp_i;
        len_o  = scaled + CNT_W'(OVERHEAD);
    end
endmodule

// File: rtl/scl_hold_point.sv
module scl_hold_point #(
    parameter int HOLD_W   = 5,
    parameter int CNT_W    = 16,
    parameter int OVERHEAD = 3
) (
    input  logic [HOLD_W-1:0] hold_i,
    input  logic [CNT_W-1:0]  low_len_i,
    output logic [CNT_W-1:0]  point_o
);
    logic [CNT_W-1:0] raw;

    always_comb begin
        raw = CNT_W'(hold_i) + CNT_W'(OVERHEAD);
        // clamp into the low phase so the strobe is never lost
        if (raw >= low_len_i) point_o = low_len_i - CNT_W'(1);
        else                  point_o = raw;
    end
endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
    import scl_wave_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             stall_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             scl_o,
    output logic             fall_stb_o,
    output logic             sda_stb_o,
    output logic             rise_stb_o,
    output logic             mid_stb_o
);
    localparam int NPH = 2; // 0 = low phase, 1 = high phase

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        wave_cfg_t        shadow;
    } gen_st_t;

    gen_st_t st_d, st_q;

    wave_cfg_t        cfg_in;
    logic [CNT_W-1:0] len_w [NPH];
    logic [CNT_W-1:0] hold_pt;
    logic [CNT_W-1:0] half_hi;
    logic             low_end, high_end;

    assign cfg_in = unpack_cfg(cfg_i);

    for (genvar g = 0; g < NPH; g++) begin : g_len
        scl_phase_len #(
            .DIV_W   (DIV_W),
            .EXP_W   (EXP_W),
            .CNT_W   (CNT_W),
            .OVERHEAD(OVERHEAD)
        ) u_len (
            .div_i(g == 0 ? st_q.shadow.lo_div : st_q.shadow.hi_div),
            .exp_i(st_q.shadow.expo),
            .len_o(len_w[g])
        );
    end

    scl_hold_point #(
        .HOLD_W  (HOLD_W),
        .CNT_W   (CNT_W),
        .OVERHEAD(OVERHEAD)
    ) u_hold (
        .hold_i   (st_q.shadow.hold),
        .low_len_i(len_w[0]),
        .point_o  (hold_pt)
    );

    assign half_hi  = len_w[1] >> 1;
    assign low_end  = (st_q.cnt == len_w[0] - CNT_W'(1));
    assign high_end = (st_q.cnt == len_w[1] - CNT_W'(1));

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (run_i) begin
                    st_d.phase  = PH_LOW;
                    st_d.cnt    = '0;
                    st_d.shadow = cfg_in;
                end
            end
            PH_LOW: begin
                if (low_end) begin
                    st_d.phase = PH_HIGH;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_HIGH: begin
                if (!stall_i) begin
                    if (high_end) begin
                        st_d.cnt = '0;
                        if (run_i) begin
                            st_d.phase  = PH_LOW;
                            st_d.shadow = cfg_in;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, shadow: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        scl_o      = (st_q.phase != PH_LOW);
        fall_stb_o = (st_q.phase == PH_LOW)  && (st_q.cnt == '0);
        sda_stb_o  = (st_q.phase == PH_LOW)  && (st_q.cnt == hold_pt);
        rise_stb_o = (st_q.phase == PH_HIGH) && (st_q.cnt == '0) && !stall_i;
        mid_stb_o  = (st_q.phase == PH_HIGH) && (st_q.cnt == half_hi) && !stall_i;
    end

    AST_STROBES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb_o, sda_stb_o, rise_stb_o, mid_stb_o})); // R11

    AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb_o |-> $past(scl_o)); // R11

    AST_SDA_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sda_stb_o |-> !scl_o); // R4

    AST_MID_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mid_stb_o |-> scl_o); // R6

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HIGH && stall_i) |=>
            (st_q.phase == PH_HIGH && st_q.cnt == $past(st_q.cnt))); // R8

    AST_CFG_ONLY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb_o |-> $stable(st_q.shadow)); // R7

    AST_LOW_IGNORES_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_LOW && !low_end) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1))); // R9

endmodule

// File: tb/scl_wave_gen_tb.sv
module scl_wave_gen_tb;

    typedef struct {
        int    kind;   // 0 fall, 1 sda, 2 rise, 3 mid
        longint t;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        stall_i = 1'b0;
    logic [31:0] cfg_i = '0;
    logic        scl_o, fall_stb_o, sda_stb_o, rise_stb_o, mid_stb_o;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    bit     done = 1'b0;
    exp_t   sb[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    scl_wave_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .stall_i   (stall_i),
        .cfg_i     (cfg_i),
        .scl_o     (scl_o),
        .fall_stb_o(fall_stb_o),
        .sda_stb_o (sda_stb_o),
        .rise_stb_o(rise_stb_o),
        .mid_stb_o (mid_stb_o)
    );

    function automatic logic [31:0] mk(input int lo, input int hi, input int ex, input int hd);
        return {3'b0, 5'(hd), 5'b0, 3'(ex), 8'(hi), 8'(lo)};
    endfunction

    function automatic int tlow(input logic [31:0] c);
        return (int'(c[7:0]) << c[18:16]) + 3;
    endfunction

    function automatic int thigh(input logic [31:0] c);
        return (int'(c[15:8]) << c[18:16]) + 3;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input int k, input longint t, input string r);
        exp_t e;
        e.kind = k; e.t = t; e.req = r;
        sb.push_back(e);
    endtask

    task automatic wait_to(input longint t);
        while (cyc < t) begin
            @(posedge clk); #1;
        end
    endtask

    // monitor: compares every produced strobe against the queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int n;
            logic [3:0] s;
            s = {mid_stb_o, rise_stb_o, sda_stb_o, fall_stb_o};
            n = $countones(s);
            if (n > 1) check(1'b0, "R11", n, 1);
            for (int k = 0; k < 4; k++) begin
                if (s[k]) begin
                    if (k == 0) check(scl_o == 1'b0, "R11", scl_o, 0);
                    if (k == 2) check(scl_o == 1'b1, "R11", scl_o, 1);
                    if (sb.size() == 0) begin
                        check(1'b0, "R10", k, -1);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(e.kind == k, e.req, k, e.kind);
                        check(e.t == cyc, e.req, cyc, e.t);
                    end
                end
            end
        end
    end

    // driver: queues the whole expected timeline, then drives inputs
    task automatic run_seq(input logic [31:0] ca, input logic [31:0] cb, input int n,
                           input int s_hi, input bit s_lo);
        longint f, r, f0, rise0;
        logic [31:0] c;
        int tl, th, sp;
        f = cyc + 1;
        f0 = f;
        rise0 = 0;
        for (int k = 0; k < n; k++) begin
            c  = (k == 0) ? ca : cb;
            tl = tlow(c);
            th = thigh(c);
            sp = int'(c[28:24]) + 3;
            push(0, f, (k == 0) ? "R10" : ((ca != cb && k == 1) ? "R7" : "R3"));
            if (sp >= tl) push(1, f + tl - 1, "R5");
            else          push(1, f + sp, "R4");
            r = f + tl + ((k == 0) ? s_hi : 0);
            if (k == 0) rise0 = f + tl;
            push(2, r, (k == 0 && s_hi > 0) ? "R8" : ((k == 0 && s_lo) ? "R9" : "R2"));
            push(3, r + th / 2, "R6");
            f = r + th;
        end
        cfg_i = ca;
        run_i = 1'b1;
        wait_to(f0 + 1);
        cfg_i = cb;
        if (s_lo) begin
            stall_i = 1'b1;
            wait_to(f0 + 2);
            stall_i = 1'b0;
        end
        if (s_hi > 0) begin
            wait_to(rise0);
            stall_i = 1'b1;
            wait_to(rise0 + s_hi);
            stall_i = 1'b0;
        end
        wait_to(f - thigh(cb) + 1 - ((n == 1) ? 0 : 0));
        run_i = 1'b0;
        wait_to(f + 4);
        check(sb.size() == 0, "R10", sb.size(), 0);
        check(scl_o == 1'b1, "R10", scl_o, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(scl_o == 1'b1, "R1", scl_o, 1);
        check({fall_stb_o, sda_stb_o, rise_stb_o, mid_stb_o} == 4'b0, "R1",
              {fall_stb_o, sda_stb_o, rise_stb_o, mid_stb_o}, 0);
        rst_n = 1'b1;
        cfg_i = mk(4, 6, 0, 0);
        repeat (4) @(posedge clk);
        #1;
        check(scl_o == 1'b1, "R1", scl_o, 1);

        run_seq(mk(4, 6, 0, 0), mk(4, 6, 0, 0), 2, 0, 1'b0);       // R2 R3 R4 R6
        run_seq(mk(3, 9, 2, 5), mk(3, 9, 2, 5), 2, 0, 1'b0);       // R2 R3 independent dividers
        run_seq(mk(0, 2, 0, 31), mk(0, 2, 0, 31), 2, 0, 1'b0);     // R5 clamp
        run_seq(mk(2, 2, 1, 1), mk(5, 1, 3, 10), 3, 0, 1'b0);      // R7 change mid-period
        run_seq(mk(1, 3, 1, 0), mk(1, 3, 1, 0), 2, 5, 1'b1);       // R8 R9 stall
        run_seq(mk(1, 1, 7, 2), mk(1, 1, 7, 2), 1, 0, 1'b0);       // R2 large exponent

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule